// File: doc/BRIEF.md
# DMA Completion Interrupt Aggregator

The block gathers completion events from the channels of a DMA engine and turns them into interrupt requests for one or more CPUs. Each event carries a 6-bit completion code, a flag that marks it as a final or an intermediate completion, and the two interrupt-enable flags copied from that transfer's options word. The final-completion enable is options bit 20 and the intermediate-completion enable is options bit 21. If the enable that matches the completion kind is set, the event sets the pending bit chosen by the code. The channel number plays no part in this choice, so any number of channels may share one code and one interrupt service routine. An early completion is returned as an ordinary event with the same flags and follows the same rule.

Software works on a 64-bit pending register, a 64-bit interrupt-enable register and one 64-bit access mask for each shadow region. Enables have separate write-one-to-set and write-one-to-clear inputs. Pending bits are cleared by writing ones. Each region mask is written whole through its own strobe. The block drives one global interrupt for all 64 codes and one interrupt for each shadow region. A system uses either the global line or the region lines, not both. Every interrupt is a registered, active-high level.

Events enter on a valid/ready stream. The block deasserts `evt_ready` only during reset and keeps it high afterwards, so it never applies back-pressure. An event counts as accepted in any cycle where `evt_valid` and `evt_ready` are both high. The sender may hold `evt_valid` as long as it likes. Because the block takes one event in every cycle it is offered, holding `evt_valid` high for several cycles delivers several events.

Top module: `dma_cmpl_irq_agg`

## Requirements
- R1: During reset and on the first cycle after it, `pend_o`, `ena_o`, every region mask, `irq_global` and `irq_region` are all zero, and `evt_ready` is low while reset is asserted.
- R2: An accepted event with code c sets pending bit c one cycle later. Codes 0 to 31 set bits of the low word at index c, and codes 32 to 63 set bit c−32 of the high word; for example, code 0x21 sets bit 33.
- R3: A final event (`evt_final`=1) sets its pending bit only when `evt_final_ie` (options bit 20) is 1. An intermediate event (`evt_final`=0) sets its pending bit only when `evt_inter_ie` (options bit 21) is 1.
- R4: An event whose matching enable is 0, or that is offered with `evt_valid` low, leaves `pend_o` unchanged.
- R5: Events from several channels that carry the same code all set the same single pending bit, and one clear removes it.
- R6: A one in `pend_clr` clears that pending bit on the next cycle. If an event sets the same bit in the same cycle, the bit stays set.
- R7: A one in `ena_set` sets that enable bit and a one in `ena_clr` clears it. When both hit the same bit in the same cycle, the set wins.
- R8: `irq_global` is high exactly one cycle after a cycle in which some bit is set in both `pend_o` and `ena_o`.
- R9: `irq_region[k]` is high exactly one cycle after a cycle in which some bit is set in `pend_o`, in `ena_o` and in region k's mask.
- R10: When `mask_we[k]` is high, region k's mask takes `mask_wdata` on the next edge, and the other regions' masks are unchanged.
- R11: After reset `evt_ready` stays high, and every cycle with `evt_valid` high is accepted as one event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_valid | input | 1 | Completion event offered |
| evt_ready | output | 1 | Event accepted when high together with valid |
| evt_code | input | 6 | Completion code selecting the pending bit |
| evt_final | input | 1 | 1 = final completion, 0 = intermediate |
| evt_final_ie | input | 1 | Final-completion interrupt enable from the options word |
| evt_inter_ie | input | 1 | Intermediate-completion interrupt enable from the options word |
| ena_set | input | 64 | Write-one-to-set interrupt enables |
| ena_clr | input | 64 | Write-one-to-clear interrupt enables |
| pend_clr | input | 64 | Write-one-to-clear pending bits |
| mask_we | input | 8 | Per-region mask write strobe |
| mask_wdata | input | 64 | Mask value for the strobed regions |
| pend_o | output | 64 | Pending register |
| ena_o | output | 64 | Enable register |
| irq_global | output | 1 | Global completion interrupt |
| irq_region | output | 8 | Per-shadow-region completion interrupts |

## Verification
The hardest case to reach is a clear and a new event landing on the same pending bit in the same cycle. This happens when an interrupt service routine acknowledges a code just as another channel that shares the code completes. The stimulus drives `pend_clr` and a matching event in one cycle and checks that the bit survives and that the interrupt stays up. It then drives the same clear alone and checks that the bit drops. The region lines are tested with overlapping masks, so that one pending bit raises some region lines and leaves others low. The test also removes a mask bit while the pending bit and its enable stay set, and checks that only that region's line falls.

// File: rtl/dci_pkg.sv
package dci_pkg;
  localparam int CODE_W    = 6;
  localparam int NUM_CODES = 1 << CODE_W;
  localparam int NUM_REGS  = 8;
  typedef logic [NUM_CODES-1:0] code_vec_t;
endpackage

// File: rtl/dci_code_decode.sv
module dci_code_decode #(
  parameter int CODE_W = dci_pkg::CODE_W,
  localparam int NCODE = 1 << CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [CODE_W-1:0] code,
  input  logic              is_final,
  input  logic              final_ie,
  input  logic              inter_ie,
  output logic [NCODE-1:0]  set_vec
);
  logic hit;
  // the enable that matches the completion kind gates the event
  assign hit = accept && (is_final ? final_ie : inter_ie);

  for (genvar i = 0; i < NCODE; i++) begin : g_bit
    assign set_vec[i] = hit && (code == CODE_W'(i));
  end

  // R2: a single event selects at most one pending bit
  p_onehot_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(set_vec));
  // R4: no set without the matching enable
  p_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept || (is_final && !final_ie) || (!is_final && !inter_ie)) |-> (set_vec == '0));
endmodule

// File: rtl/dci_w1_reg.sv
module dci_w1_reg #(
  parameter int WIDTH = dci_pkg::NUM_CODES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] q
);
  // set wins over clear on the same bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= (q & ~clr_i) | set_i;
  end

  // R6 (pending instance) and R7 (enable instance): set lands even when cleared
  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((q & $past(set_i)) == $past(set_i)));
  // R7 (also covers R6): clear without set removes the bit
  p_clear_takes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_i & ~set_i) != '0) |=> ((q & $past(clr_i & ~set_i)) == '0));
  // R4: bits untouched by set and clear hold
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_i == '0) && (clr_i == '0)) |=> $stable(q));
endmodule

// File: rtl/dci_region_masks.sv
module dci_region_masks #(
  parameter int NREG  = dci_pkg::NUM_REGS,
  parameter int WIDTH = dci_pkg::NUM_CODES
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NREG-1:0]           we,
  input  logic [WIDTH-1:0]          wdata,
  output logic [NREG-1:0][WIDTH-1:0] mask
);
  for (genvar k = 0; k < NREG; k++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     mask[k] <= '0;
      else if (we[k]) mask[k] <= wdata;
    end
    // R10: an unstrobed region keeps its mask
    p_mask_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !we[k] |=> $stable(mask[k]));
    p_mask_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
      we[k] |=> (mask[k] == $past(wdata)));
  end
endmodule

// File: rtl/dci_irq_gen.sv
module dci_irq_gen #(
  parameter int NREG  = dci_pkg::NUM_REGS,
  parameter int WIDTH = dci_pkg::NUM_CODES
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [WIDTH-1:0]           pend,
  input  logic [WIDTH-1:0]           ena,
  input  logic [NREG-1:0][WIDTH-1:0] mask,
  output logic                       irq_global,
  output logic [NREG-1:0]            irq_region
);
  logic [WIDTH-1:0] live;
  assign live = pend & ena;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_global <= 1'b0;
    else        irq_global <= |live;
  end

  for (genvar k = 0; k < NREG; k++) begin : g_irq
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_region[k] <= 1'b0;
      else        irq_region[k] <= |(live & mask[k]);
    end
    // R9: a region line never rises without the global condition
    p_region_in_global_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_region[k] |-> irq_global);
  end

  // R8: the global line follows pending-and-enabled one cycle later
  p_global_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & ena) != '0) |=> irq_global);
  p_global_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & ena) == '0) |=> !irq_global);
endmodule

// File: rtl/dma_cmpl_irq_agg.sv
module dma_cmpl_irq_agg #(
  parameter int CODE_W = dci_pkg::CODE_W,
  parameter int NREG   = dci_pkg::NUM_REGS,
  localparam int NCODE = 1 << CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  output logic              evt_ready,
  input  logic [CODE_W-1:0] evt_code,
  input  logic              evt_final,
  input  logic              evt_final_ie,
  input  logic              evt_inter_ie,
  input  logic [NCODE-1:0]  ena_set,
  input  logic [NCODE-1:0]  ena_clr,
  input  logic [NCODE-1:0]  pend_clr,
  input  logic [NREG-1:0]   mask_we,
  input  logic [NCODE-1:0]  mask_wdata,
  output logic [NCODE-1:0]  pend_o,
  output logic [NCODE-1:0]  ena_o,
  output logic              irq_global,
  output logic [NREG-1:0]   irq_region
);
  logic                      accept;
  logic [NCODE-1:0]          set_vec;
  logic [NREG-1:0][NCODE-1:0] mask;

  // ready rises on the first edge after reset and stays high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_ready <= 1'b0;
    else        evt_ready <= 1'b1;
  end
  assign accept = evt_valid && evt_ready;

  dci_code_decode #(.CODE_W(CODE_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .accept(accept), .code(evt_code),
    .is_final(evt_final), .final_ie(evt_final_ie), .inter_ie(evt_inter_ie),
    .set_vec(set_vec)
  );

  dci_w1_reg #(.WIDTH(NCODE)) u_pend (
    .clk(clk), .rst_n(rst_n), .set_i(set_vec), .clr_i(pend_clr), .q(pend_o)
  );

  dci_w1_reg #(.WIDTH(NCODE)) u_ena (
    .clk(clk), .rst_n(rst_n), .set_i(ena_set), .clr_i(ena_clr), .q(ena_o)
  );

  dci_region_masks #(.NREG(NREG), .WIDTH(NCODE)) u_masks (
    .clk(clk), .rst_n(rst_n), .we(mask_we), .wdata(mask_wdata), .mask(mask)
  );

  dci_irq_gen #(.NREG(NREG), .WIDTH(NCODE)) u_irq (
    .clk(clk), .rst_n(rst_n), .pend(pend_o), .ena(ena_o), .mask(mask),
    .irq_global(irq_global), .irq_region(irq_region)
  );

  // R11: once out of reset the block never stalls the stream
  p_ready_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> evt_ready);
  // R2: an accepted, enabled event shows up in pending
  p_event_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && evt_final && evt_final_ie) |=> pend_o[$past(evt_code)]);
endmodule

// File: tb/dma_cmpl_irq_agg_tb.sv
module dma_cmpl_irq_agg_tb;
  localparam int NC = 64;
  localparam int NR = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic evt_valid = 1'b0, evt_ready;
  logic [5:0] evt_code = '0;
  logic evt_final = 1'b0, evt_final_ie = 1'b0, evt_inter_ie = 1'b0;
  logic [NC-1:0] ena_set = '0, ena_clr = '0, pend_clr = '0, mask_wdata = '0;
  logic [NR-1:0] mask_we = '0;
  logic [NC-1:0] pend_o, ena_o;
  logic irq_global;
  logic [NR-1:0] irq_region;

  always #5 clk = ~clk;

  dma_cmpl_irq_agg u_dut (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_ready(evt_ready),
    .evt_code(evt_code), .evt_final(evt_final), .evt_final_ie(evt_final_ie),
    .evt_inter_ie(evt_inter_ie), .ena_set(ena_set), .ena_clr(ena_clr),
    .pend_clr(pend_clr), .mask_we(mask_we), .mask_wdata(mask_wdata),
    .pend_o(pend_o), .ena_o(ena_o), .irq_global(irq_global), .irq_region(irq_region)
  );

  typedef struct {
    logic [NC-1:0] pend;
    logic [NC-1:0] ena;
    logic          g;
    logic [NR-1:0] r;
    string         tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [NC-1:0] m_pend = '0, m_ena = '0;
  logic [NC-1:0] m_mask [NR];

  task automatic check(input string tag, input logic [NC-1:0] act, input logic [NC-1:0] exp_v, input string what);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp_v);
    end
  endtask

  // driver: drive one cycle of stimulus and push the expected outputs after the next edge
  task automatic cyc(input logic v, input logic [5:0] code, input logic fin,
                     input logic fie, input logic iie,
                     input logic [NC-1:0] es, input logic [NC-1:0] ec,
                     input logic [NC-1:0] pc, input logic [NR-1:0] mwe,
                     input logic [NC-1:0] md, input string tag);
    exp_t e;
    logic [NC-1:0] setv;
    @(negedge clk);
    evt_valid = v; evt_code = code; evt_final = fin;
    evt_final_ie = fie; evt_inter_ie = iie;
    ena_set = es; ena_clr = ec; pend_clr = pc; mask_we = mwe; mask_wdata = md;
    // interrupts register the state as it stands before this edge
    e.g = |(m_pend & m_ena);
    for (int k = 0; k < NR; k++) e.r[k] = |(m_pend & m_ena & m_mask[k]);
    setv = '0;
    if (v && (fin ? fie : iie)) setv[code] = 1'b1;
    m_pend = (m_pend & ~pc) | setv;
    m_ena  = (m_ena & ~ec) | es;
    for (int k = 0; k < NR; k++) if (mwe[k]) m_mask[k] = md;
    e.pend = m_pend; e.ena = m_ena; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input string tag);
    cyc(1'b0, 6'd0, 1'b0, 1'b0, 1'b0, '0, '0, '0, '0, '0, tag);
  endtask

  task automatic evt(input logic [5:0] code, input logic fin, input logic fie,
                     input logic iie, input string tag);
    cyc(1'b1, code, fin, fie, iie, '0, '0, '0, '0, '0, tag);
  endtask

  // monitor: compare each expected item just after the edge it belongs to
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(e.tag, pend_o, e.pend, "pend_o");
        check(e.tag, ena_o, e.ena, "ena_o");
        check(e.tag, {63'd0, irq_global}, {63'd0, e.g}, "irq_global");
        check(e.tag, {56'd0, irq_region}, {56'd0, e.r}, "irq_region");
        check("R11", {63'd0, evt_ready}, 64'd1, "evt_ready");
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NR; k++) m_mask[k] = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check("R1", pend_o, '0, "pend_o in reset");
    check("R1", ena_o, '0, "ena_o in reset");
    check("R1", {55'd0, irq_global, irq_region}, '0, "irqs in reset");
    check("R1", {63'd0, evt_ready}, '0, "evt_ready in reset");
    @(negedge clk);
    rst_n = 1'b1;
    idle("R1");

    // R10: masks, overlapping: region0 low word, region1 bit 33, region2 all, region3 none
    cyc(1'b0, 0, 0, 0, 0, '0, '0, '0, 8'b0000_0001, 64'h0000_0000_FFFF_FFFF, "R10");
    cyc(1'b0, 0, 0, 0, 0, '0, '0, '0, 8'b0000_0010, 64'h0000_0002_0000_0000, "R10");
    cyc(1'b0, 0, 0, 0, 0, '0, '0, '0, 8'b0000_0100, '1, "R10");

    // R3 / R4: disabled kinds and invalid events set nothing
    evt(6'd5, 1'b1, 1'b0, 1'b1, "R4");
    evt(6'd6, 1'b0, 1'b1, 1'b0, "R4");
    cyc(1'b0, 6'd7, 1'b1, 1'b1, 1'b1, '0, '0, '0, '0, '0, "R4");
    // R2 / R3: enabled final and intermediate completions
    evt(6'd0, 1'b1, 1'b1, 1'b0, "R3");
    evt(6'h21, 1'b0, 1'b0, 1'b1, "R2");
    evt(6'd63, 1'b1, 1'b1, 1'b1, "R2");
    evt(6'd31, 1'b0, 1'b1, 1'b1, "R2");
    idle("R2");

    // R8 / R9: enable bit 33 -> global, region1, region2 rise
    cyc(1'b0, 0, 0, 0, 0, 64'h0000_0002_0000_0000, '0, '0, '0, '0, "R7");
    idle("R8");
    idle("R9");
    // R9: drop bit 33 from region1 mask only
    cyc(1'b0, 0, 0, 0, 0, '0, '0, '0, 8'b0000_0010, '0, "R10");
    idle("R9");
    idle("R9");

    // R5: two channels sharing code 9, then one clear removes it
    cyc(1'b0, 0, 0, 0, 0, 64'h200, '0, '0, '0, '0, "R7");
    evt(6'd9, 1'b1, 1'b1, 1'b0, "R5");
    evt(6'd9, 1'b0, 1'b0, 1'b1, "R5");
    idle("R5");
    cyc(1'b0, 0, 0, 0, 0, '0, '0, 64'h200, '0, '0, "R5");
    idle("R5");
    idle("R5");

    // R6: clear and set on the same bit -> set wins, then clear alone
    evt(6'd9, 1'b1, 1'b1, 1'b0, "R6");
    cyc(1'b1, 6'd9, 1'b1, 1'b1, 1'b0, '0, '0, 64'h200, '0, '0, "R6");
    idle("R6");
    cyc(1'b0, 0, 0, 0, 0, '0, '0, 64'h200, '0, '0, "R6");
    idle("R6");

    // R7: enable set and clear on the same bit, then clear alone
    cyc(1'b0, 0, 0, 0, 0, 64'h1, 64'h1, '0, '0, '0, "R7");
    idle("R8");
    cyc(1'b0, 0, 0, 0, 0, '0, 64'h1, '0, '0, '0, "R7");
    idle("R7");

    // R11: valid held high for three cycles delivers three events
    evt(6'd40, 1'b1, 1'b1, 1'b0, "R11");
    evt(6'd41, 1'b1, 1'b1, 1'b0, "R11");
    evt(6'd42, 1'b1, 1'b1, 1'b0, "R11");
    // clear all pending, irqs fall
    cyc(1'b0, 0, 0, 0, 0, '0, '0, '1, '0, '0, "R6");
    idle("R8");
    idle("R9");
    idle("R8");

    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule